// File: doc/BRIEF.md
# Display Bridge Control Register Target

This block holds the register state behind the I2C control port of a display transmitter. An I2C target front end, which is not part of this block, decodes the serial bus. It hands over one event per clock: a write transaction began, a read transaction began, a byte was received, or the controller wants a byte. The block keeps an 8-bit register pointer and a two-flag control register that carries a request and grant handshake for the auxiliary DDC bus. It also answers reads of a fixed chip identifier and of an interrupt status that always reports a display as plugged.

The first byte of every write transaction selects the register pointer. Each later byte, written or read, moves the pointer on by one. A read transaction carries on from wherever the last write left the pointer. The `ddc_mode` output is high while the host holds the auxiliary bus, so that surrounding logic can steer the bus to the display-data target.

Top module: `vbc_top`

## Requirements
- R1: The first byte received after a write-start event loads the pointer, and that byte reaches no register. A later write-start arms the load again.
- R2: Every byte received after the load, and every byte read, advances the pointer by one. The pointer wraps from 0xFF to 0x00.
- R3: A read at pointer 0x1B returns 0xB0.
- R4: A read at pointer 0x3D returns 0x04.
- R5: A byte written at pointer 0x1A with bit 2 set makes the request pending. If bit 1 is also set, `ddc_mode` goes high. If bit 1 is clear, `ddc_mode` keeps its previous value.
- R6: A byte written at pointer 0x1A with bit 2 clear clears both the pending request and `ddc_mode`.
- R7: A read at pointer 0x1A returns 0x06 while the request is pending, and 0x00 otherwise.
- R8: A read at any other pointer returns 0x00. A write at any other pointer only advances the pointer.
- R9: After reset the pointer is 0, no load is armed, no request is pending, `ddc_mode` is low, `rd_valid` is low and `rd_data` is 0x00.
- R10: A read-start event leaves the pointer unchanged, so reads continue from the pointer set by the last write.
- R11: The byte for a read request appears on `rd_data` with `rd_valid` high one clock after `rd_req`. `rd_valid` lasts one clock, and `rd_data` holds its value until the next read.
- R12: When several events arrive in one clock, only the first of this order takes effect: write-start, read-start, write byte, read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_wr_start | input | 1 | A write transaction addressed to this target began |
| ev_rd_start | input | 1 | A read transaction addressed to this target began |
| wr_valid | input | 1 | A byte was received from the controller |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | The front end needs the next byte to send |
| rd_data | output | 8 | Byte returned for the last read request |
| rd_valid | output | 1 | One-clock strobe: rd_data was just updated |
| ddc_mode | output | 1 | High while the auxiliary DDC bus is granted |

## Verification
Pointer loading is tried both with a lone write-start and with long bursts. The bursts show whether the load byte is kept apart from register writes, and whether writes and reads advance the pointer the same way, across 0xFF. Control bytes go in with request and grant both set, with request alone after a grant, and with request clear. These separate the grant, hold and cancel paths. Writes to a neighbouring address show that only 0x1A decodes. Events arriving together, and a read-start placed between a write and its reads, show the priority order and that a read-start does not reload the pointer.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

  localparam int DATA_W  = 8;
  localparam int REQ_BIT = 2;
  localparam int GNT_BIT = 1;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_WSTART = 3'd1,
    EV_RSTART = 3'd2,
    EV_WBYTE  = 3'd3,
    EV_RBYTE  = 3'd4
  } vbc_event_e;

  function automatic logic [DATA_W-1:0] ctrl_readback(input logic pending);
    logic [DATA_W-1:0] v;
    v = '0;
    v[REQ_BIT] = pending;
    v[GNT_BIT] = pending;
    return v;
  endfunction

endpackage

// File: rtl/vbc_event_decode.sv
module vbc_event_decode
  import vbc_pkg::*;
(
  input  logic       ev_wr_start,
  input  logic       ev_rd_start,
  input  logic       wr_valid,
  input  logic       rd_req,
  output vbc_event_e ev
);

  always_comb begin
    if (ev_wr_start)      ev = EV_WSTART;
    else if (ev_rd_start) ev = EV_RSTART;
    else if (wr_valid)    ev = EV_WBYTE;
    else if (rd_req)      ev = EV_RBYTE;
    else                  ev = EV_NONE;
  end

endmodule

// File: rtl/vbc_pointer.sv
module vbc_pointer
  import vbc_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vbc_event_e        ev,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              load_armed,
  output logic              reg_write
);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  logic ptr_load_evt;
  logic ptr_inc_evt;

  assign ptr_load_evt = (ev == EV_WBYTE) && load_armed;
  assign reg_write    = (ev == EV_WBYTE) && !load_armed;
  assign ptr_inc_evt  = reg_write || (ev == EV_RBYTE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= '0;
      load_armed <= 1'b0;
    end else begin
      if (ev == EV_WSTART) load_armed <= 1'b1;
      else if (ptr_load_evt) load_armed <= 1'b0;
      if (ptr_load_evt)     ptr <= wr_data[PTR_W-1:0];
      else if (ptr_inc_evt) ptr <= ptr_next(ptr);
    end
  end

  // R1
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load_evt |=> (ptr == $past(wr_data[PTR_W-1:0])) && !load_armed);

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc_evt |=> ptr == PTR_W'($past(ptr) + 1'b1));

  // R10
  rstart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_RSTART) |=> $stable(ptr));

endmodule

// File: rtl/vbc_ctrl_reg.sv
module vbc_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic req_bit,
  input  logic gnt_bit,
  output logic req_pending,
  output logic ddc_active
);

  logic grant_evt;
  logic cancel_evt;

  assign grant_evt  = ctrl_wr && req_bit && gnt_bit;
  assign cancel_evt = ctrl_wr && !req_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_pending <= 1'b0;
      ddc_active  <= 1'b0;
    end else if (ctrl_wr) begin
      req_pending <= req_bit;
      if (grant_evt)       ddc_active <= 1'b1;
      else if (cancel_evt) ddc_active <= 1'b0;
    end
  end

  // R5
  grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |=> ddc_active && req_pending);

  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> !ddc_active && !req_pending);

  // R5
  mode_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ddc_active |-> req_pending);

endmodule

// File: rtl/vbc_read_mux.sv
module vbc_read_mux
  import vbc_pkg::*;
#(
  parameter int                PTR_W     = 8,
  parameter logic [PTR_W-1:0]  CTRL_PTR  = 'h1A,
  parameter logic [PTR_W-1:0]  ID_PTR    = 'h1B,
  parameter logic [PTR_W-1:0]  IRQ_PTR   = 'h3D,
  parameter logic [DATA_W-1:0] ID_VALUE  = 8'hB0,
  parameter logic [DATA_W-1:0] IRQ_VALUE = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              req_pending,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  function automatic logic [DATA_W-1:0] read_value(input logic [PTR_W-1:0] p,
                                                   input logic pend);
    if (p == CTRL_PTR)     return ctrl_readback(pend);
    else if (p == ID_PTR)  return ID_VALUE;
    else if (p == IRQ_PTR) return IRQ_VALUE;
    else                   return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= read_value(ptr, req_pending);
    end
  end

  // R11
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rd_valid && $stable(rd_data));

  // R3
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && ptr == ID_PTR) |=> rd_data == ID_VALUE);

endmodule

// File: rtl/vbc_top.sv
module vbc_top
  import vbc_pkg::*;
#(
  parameter int          PTR_W     = 8,
  parameter int unsigned CTRL_ADDR = 'h1A,
  parameter int unsigned ID_ADDR   = 'h1B,
  parameter int unsigned IRQ_ADDR  = 'h3D,
  parameter int unsigned ID_VALUE  = 'hB0,
  parameter int unsigned IRQ_VALUE = 'h04
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_wr_start,
  input  logic       ev_rd_start,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       rd_req,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       ddc_mode
);

  localparam logic [PTR_W-1:0]  CTRL_PTR = CTRL_ADDR[PTR_W-1:0];
  localparam logic [PTR_W-1:0]  ID_PTR   = ID_ADDR[PTR_W-1:0];
  localparam logic [PTR_W-1:0]  IRQ_PTR  = IRQ_ADDR[PTR_W-1:0];
  localparam logic [DATA_W-1:0] ID_VAL   = ID_VALUE[DATA_W-1:0];
  localparam logic [DATA_W-1:0] IRQ_VAL  = IRQ_VALUE[DATA_W-1:0];

  vbc_event_e       ev;
  logic [PTR_W-1:0] ptr;
  logic             load_armed;
  logic             reg_write;
  logic             ctrl_wr;
  logic             req_pending;
  logic             rd_fire;

  vbc_event_decode u_dec (
    .ev_wr_start (ev_wr_start),
    .ev_rd_start (ev_rd_start),
    .wr_valid    (wr_valid),
    .rd_req      (rd_req),
    .ev          (ev)
  );

  vbc_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .wr_data    (wr_data),
    .ptr        (ptr),
    .load_armed (load_armed),
    .reg_write  (reg_write)
  );

  assign ctrl_wr = reg_write && (ptr == CTRL_PTR);
  assign rd_fire = (ev == EV_RBYTE);

  vbc_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr     (ctrl_wr),
    .req_bit     (wr_data[REQ_BIT]),
    .gnt_bit     (wr_data[GNT_BIT]),
    .req_pending (req_pending),
    .ddc_active  (ddc_mode)
  );

  vbc_read_mux #(
    .PTR_W     (PTR_W),
    .CTRL_PTR  (CTRL_PTR),
    .ID_PTR    (ID_PTR),
    .IRQ_PTR   (IRQ_PTR),
    .ID_VALUE  (ID_VAL),
    .IRQ_VALUE (IRQ_VAL)
  ) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire     (rd_fire),
    .ptr         (ptr),
    .req_pending (req_pending),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

  // R12
  wstart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_start && rd_req) |=> !rd_valid);

  // R8
  other_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_write && ptr != CTRL_PTR) |=> $stable(ddc_mode));

endmodule

// File: tb/tb_vbc_top.sv
`timescale 1ns/1ps
module tb_vbc_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_wr_start = 1'b0;
  logic       ev_rd_start = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_req = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       ddc_mode;

  int compared = 0;
  int mismatched = 0;

  // behavioural reference state
  int  m_ptr = 0;
  bit  m_load = 0;
  bit  m_req = 0;
  bit  m_ddc = 0;
  bit  m_rdv = 0;
  int  m_rdd = 0;

  always #10 clk = ~clk;

  vbc_top dut (
    .clk(clk), .rst_n(rst_n), .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .ddc_mode(ddc_mode)
  );

  function automatic int model_read(int p);
    case (p)
      26: return m_req ? 6 : 0;
      27: return 176;
      61: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    check({tag, " ddc_mode"}, int'(ddc_mode), int'(m_ddc));
    check("R11 rd_valid", int'(rd_valid), int'(m_rdv));
    check({tag, " rd_data"}, int'(rd_data), m_rdd);
  endtask

  task automatic step(input bit ws, input bit rs, input bit wv, input int wd,
                      input bit rr, input string tag);
    ev_wr_start = ws; ev_rd_start = rs; wr_valid = wv; wr_data = 8'(wd); rd_req = rr;
    m_rdv = 0;
    if (ws) m_load = 1;
    else if (rs) begin end
    else if (wv) begin
      if (m_load) begin m_ptr = wd % 256; m_load = 0; end
      else begin
        if (m_ptr == 26) begin
          if ((wd / 4) % 2 == 1) begin
            m_req = 1;
            if ((wd / 2) % 2 == 1) m_ddc = 1;
          end else begin
            m_req = 0; m_ddc = 0;
          end
        end
        m_ptr = (m_ptr + 1) % 256;
      end
    end else if (rr) begin
      m_rdd = model_read(m_ptr);
      m_rdv = 1;
      m_ptr = (m_ptr + 1) % 256;
    end
    @(posedge clk);
    @(negedge clk);
    ev_wr_start = 0; ev_rd_start = 0; wr_valid = 0; wr_data = 0; rd_req = 0;
    compare_all(tag);
  endtask

  task automatic set_ptr(input int p, input string tag);
    step(1, 0, 0, 0, 0, tag);
    step(0, 0, 1, p, 0, tag);
  endtask
  task automatic wr_byte(input int d, input string tag);
    step(0, 0, 1, d, 0, tag);
  endtask
  task automatic rd_byte(input string tag);
    step(0, 0, 0, 0, 1, tag);
  endtask
  task automatic rd_begin(input string tag);
    step(0, 1, 0, 0, 0, tag);
  endtask

  initial begin
    #(20ns * 20000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all("R9");
    rd_byte("R9");                      // pointer 0 after reset reads 0x00
    step(0, 0, 0, 0, 0, "R11");         // strobe drops, data held

    set_ptr(8'h1B, "R1");
    rd_begin("R10");
    rd_byte("R3");
    rd_byte("R2");
    rd_byte("R8");

    set_ptr(8'h3D, "R4");
    rd_begin("R10");
    rd_byte("R4");

    set_ptr(8'h1A, "R1");               // load byte 0x1A is not a ctrl write
    rd_byte("R7");

    set_ptr(8'h1A, "R5");
    wr_byte(8'h04, "R5");               // request only: mode stays low
    set_ptr(8'h1A, "R7");
    rd_byte("R7");
    set_ptr(8'h1A, "R5");
    wr_byte(8'h06, "R5");               // request and grant
    set_ptr(8'h1A, "R5");
    wr_byte(8'h04, "R5");               // request only: mode held high
    set_ptr(8'h1A, "R6");
    wr_byte(8'h02, "R6");               // request clear cancels both
    rd_byte("R6");                      // pointer now 0x1B
    set_ptr(8'h1A, "R7");
    rd_byte("R7");

    set_ptr(8'h19, "R8");
    wr_byte(8'h06, "R8");               // 0x19: no effect
    wr_byte(8'h06, "R2");               // 0x1A: grant via increment
    rd_begin("R10");
    rd_byte("R3");                      // 0x1B
    set_ptr(8'h18, "R8");
    wr_byte(8'hFF, "R8");
    wr_byte(8'hFF, "R8");
    set_ptr(8'h1A, "R7");
    rd_byte("R7");

    set_ptr(8'hFE, "R2");
    rd_byte("R2");
    rd_byte("R2");                      // 0xFF
    rd_byte("R2");                      // wrapped to 0x00
    set_ptr(8'hFF, "R2");
    wr_byte(8'h00, "R2");               // write wraps too
    rd_byte("R2");                      // 0x00

    step(1, 0, 1, 8'h55, 0, "R12");     // write-start beats write byte
    wr_byte(8'h1B, "R12");              // so this byte loads the pointer
    rd_byte("R12");
    step(0, 1, 0, 0, 1, "R12");         // read-start beats read request
    rd_byte("R12");
    set_ptr(8'h1A, "R12");
    step(0, 0, 1, 8'h00, 1, "R12");     // write byte beats read request
    step(1, 0, 0, 0, 1, "R12");
    step(0, 0, 1, 8'h1A, 0, "R1");
    rd_byte("R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule